// File: doc/BRIEF.md
# Affine Subscript Dependence Checker

This block decides whether two affine array accesses inside a loop can ever collide. The write side uses index `a*i+b` and the read side uses index `c*i+d`, with all four coefficients constant signed integers. A collision is ruled out whenever the greatest common divisor of the two multipliers fails to divide the offset gap `d-b`. When the divisor does divide the gap, the block reports that a dependence is only possible. Loop bounds are never consulted, so a "possible" answer may be a false alarm.

A request carries the four coefficients and is taken through a valid/ready handshake. A binary GCD datapath works on the magnitudes of the multipliers, one step per clock. A shift-and-subtract remainder unit then tests the magnitude of the gap against that divisor, one bit per clock. The verdict and the divisor appear together with a single-cycle completion pulse.

Top module: `gcd_dep_tester`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `dep_possible` and `gcd_out` are 0 and `req_ready` is 1.
- R2: A request is taken only in a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after a non-trivial acceptance until the result and also in the `done` cycle. Coefficients are captured when taken, so later changes on the coefficient inputs do not alter the result.
- R3: Coefficients are 16-bit two's complement. `gcd_out` equals gcd(|a|,|c|) as an unsigned 16-bit value, with signs of any mix.
- R4: `dep_possible` is 1 exactly when `gcd_out` divides `d-b`, and 0 (independent) otherwise. For example, a=2, b=3, c=2, d=0 gives divisor 2 and result 0. A divisor of 1 always yields 1.
- R5: When exactly one multiplier is zero, `gcd_out` is the magnitude of the other one, and the divisibility rule of R4 applies to it.
- R6: When both multipliers are zero, `gcd_out` is 0 and `dep_possible` is 1 only if b equals d. `done` rises in the cycle after acceptance.
- R7: `done` is high for exactly one cycle per request. `gcd_out` and `dep_possible` change only in a `done` cycle and hold until the next one.
- R8: The extreme value -32768 is handled: its magnitude reads 0x8000 on `gcd_out`. An offset gap of up to ±65535 is tested without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| coef_a | input | 16 | Signed multiplier of the write index |
| coef_b | input | 16 | Signed offset of the write index |
| coef_c | input | 16 | Signed multiplier of the read index |
| coef_d | input | 16 | Signed offset of the read index |
| done | output | 1 | Single-cycle result strobe |
| dep_possible | output | 1 | 1: dependence possible, 0: independent |
| gcd_out | output | 16 | Unsigned GCD of the multiplier magnitudes |

## Verification
The assertions assume that `req_valid` is only meaningful while the coefficients on the inputs are the ones intended for that cycle. They also assume that the block is always given enough cycles to finish, because no abort exists. The zero-multiplier check relates the result to the offsets seen at acceptance, so it relies on the requester not treating a request as taken before `req_ready` was high. The stimulus keeps to these limits. It raises `req_valid` for a single accepted cycle and then deliberately scrambles the coefficients while the block is busy. It waits for `done` before sending the next request.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GCD  = 2'd1,
    ST_DIV  = 2'd2
  } gdt_state_e;

endpackage

// File: rtl/gdt_operand_prep.sv
module gdt_operand_prep #(
  parameter int unsigned COEF_W = 16
) (
  input  logic signed [COEF_W-1:0] mul_w,
  input  logic signed [COEF_W-1:0] off_w,
  input  logic signed [COEF_W-1:0] mul_r,
  input  logic signed [COEF_W-1:0] off_r,
  output logic        [COEF_W-1:0] mag_w,
  output logic        [COEF_W-1:0] mag_r,
  output logic        [COEF_W:0]   gap_mag,
  output logic                     both_zero,
  output logic                     offs_equal
);
  localparam int unsigned GAP_W = COEF_W + 1;

  logic [1:0][COEF_W-1:0] mul_in;
  logic [1:0][COEF_W-1:0] mag_out;

  assign mul_in[0] = mul_w;
  assign mul_in[1] = mul_r;

  for (genvar g = 0; g < 2; g++) begin : g_abs
    always_comb begin
      if (mul_in[g][COEF_W-1]) begin
        mag_out[g] = ~mul_in[g] + 1'b1;
      end else begin
        mag_out[g] = mul_in[g];
      end
    end
  end

  assign mag_w = mag_out[0];
  assign mag_r = mag_out[1];

  logic signed [GAP_W-1:0] gap;

  always_comb begin
    gap = $signed({off_r[COEF_W-1], off_r}) - $signed({off_w[COEF_W-1], off_w});
    if (gap[GAP_W-1]) begin
      gap_mag = ~gap + 1'b1;
    end else begin
      gap_mag = gap;
    end
  end

  assign both_zero  = (mul_w == '0) && (mul_r == '0);
  assign offs_equal = (off_w == off_r);

endmodule

// File: rtl/gdt_gcd_engine.sv
module gdt_gcd_engine #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic         fin,
  output logic [W-1:0] g
);
  localparam int unsigned KW = $clog2(W + 1);

  logic          run_q, run_n;
  logic          fin_q, fin_n;
  logic [W-1:0]  x_q, x_n, y_q, y_n, g_q, g_n;
  logic [KW-1:0] k_q, k_n;
  logic          dp_en;

  assign dp_en = start | run_q;

  always_comb begin
    run_n = run_q;
    fin_n = 1'b0;
    x_n   = x_q;
    y_n   = y_q;
    k_n   = k_q;
    g_n   = g_q;
    if (start) begin
      x_n   = op_x;
      y_n   = op_y;
      k_n   = '0;
      run_n = 1'b1;
    end else if (run_q) begin
      if ((x_q == '0) || (y_q == '0)) begin
        g_n   = (x_q | y_q) << k_q;
        fin_n = 1'b1;
        run_n = 1'b0;
      end else if (!x_q[0] && !y_q[0]) begin
        x_n = x_q >> 1;
        y_n = y_q >> 1;
        k_n = k_q + 1'b1;
      end else if (!x_q[0]) begin
        x_n = x_q >> 1;
      end else if (!y_q[0]) begin
        y_n = y_q >> 1;
      end else if (x_q >= y_q) begin
        x_n = (x_q - y_q) >> 1;
      end else begin
        y_n = (y_q - x_q) >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      k_q   <= '0;
      g_q   <= '0;
    end else begin
      run_q <= run_n;
      fin_q <= fin_n;
      if (dp_en) begin
        x_q <= x_n;
        y_q <= y_n;
        k_q <= k_n;
      end
      if (fin_n) begin
        g_q <= g_n;
      end
    end
  end

  assign fin = fin_q;
  assign g   = g_q;

endmodule

// File: rtl/gdt_rem_unit.sv
module gdt_rem_unit #(
  parameter int unsigned NUM_W = 17,
  parameter int unsigned DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             fin,
  output logic             rem_zero
);
  localparam int unsigned REM_W = DEN_W + 1;
  localparam int unsigned CW    = $clog2(NUM_W + 1);

  logic             run_q, run_n;
  logic             fin_q, fin_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [NUM_W-1:0] num_q, num_n;
  logic [REM_W-1:0] rem_q, rem_n;
  logic [DEN_W-1:0] den_q, den_n;
  logic [REM_W-1:0] trial, den_ext;
  logic             dp_en;

  assign dp_en   = start | run_q;
  assign trial   = {rem_q[REM_W-2:0], num_q[NUM_W-1]};
  assign den_ext = {1'b0, den_q};

  always_comb begin
    run_n = run_q;
    fin_n = 1'b0;
    cnt_n = cnt_q;
    num_n = num_q;
    rem_n = rem_q;
    den_n = den_q;
    if (start) begin
      num_n = dividend;
      den_n = divisor;
      rem_n = '0;
      cnt_n = CW'(NUM_W);
      run_n = 1'b1;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        rem_n = (trial >= den_ext) ? (trial - den_ext) : trial;
        num_n = num_q << 1;
        cnt_n = cnt_q - 1'b1;
      end else begin
        fin_n = 1'b1;
        run_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      cnt_q <= '0;
      num_q <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else begin
      run_q <= run_n;
      fin_q <= fin_n;
      if (dp_en) begin
        cnt_q <= cnt_n;
        num_q <= num_n;
        rem_q <= rem_n;
        den_q <= den_n;
      end
    end
  end

  assign fin      = fin_q;
  assign rem_zero = (rem_q == '0);

endmodule

// File: rtl/gcd_dep_tester.sv
module gcd_dep_tester #(
  parameter int unsigned COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [COEF_W-1:0] coef_a,
  input  logic [COEF_W-1:0] coef_b,
  input  logic [COEF_W-1:0] coef_c,
  input  logic [COEF_W-1:0] coef_d,
  output logic              done,
  output logic              dep_possible,
  output logic [COEF_W-1:0] gcd_out
);
  import gdt_pkg::*;

  localparam int unsigned GAP_W = COEF_W + 1;

  gdt_state_e        state_q, state_n;
  logic              done_q, done_n;
  logic              dep_q, dep_n;
  logic [COEF_W-1:0] gcd_q, gcd_n;
  logic [GAP_W-1:0]  gap_q;

  logic [COEF_W-1:0] mag_w, mag_r;
  logic [GAP_W-1:0]  gap_mag;
  logic              both_zero, offs_equal;
  logic              accept, gcd_start, gcd_fin, div_start, div_fin, rem_zero;
  logic [COEF_W-1:0] gcd_val;

  gdt_operand_prep #(.COEF_W(COEF_W)) u_prep (
    .mul_w      (coef_a),
    .off_w      (coef_b),
    .mul_r      (coef_c),
    .off_r      (coef_d),
    .mag_w      (mag_w),
    .mag_r      (mag_r),
    .gap_mag    (gap_mag),
    .both_zero  (both_zero),
    .offs_equal (offs_equal)
  );

  assign req_ready = (state_q == ST_IDLE) && !done_q;
  assign accept    = req_valid && req_ready;
  assign gcd_start = accept && !both_zero;
  assign div_start = (state_q == ST_GCD) && gcd_fin;

  gdt_gcd_engine #(.W(COEF_W)) u_gcd (
    .clk   (clk),
    .rst_n (rst_n),
    .start (gcd_start),
    .op_x  (mag_w),
    .op_y  (mag_r),
    .fin   (gcd_fin),
    .g     (gcd_val)
  );

  gdt_rem_unit #(.NUM_W(GAP_W), .DEN_W(COEF_W)) u_rem (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (gap_q),
    .divisor  (gcd_val),
    .fin      (div_fin),
    .rem_zero (rem_zero)
  );

  always_comb begin
    state_n = state_q;
    done_n  = 1'b0;
    dep_n   = dep_q;
    gcd_n   = gcd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (both_zero) begin
            done_n = 1'b1;
            dep_n  = offs_equal;
            gcd_n  = '0;
          end else begin
            state_n = ST_GCD;
          end
        end
      end
      ST_GCD: begin
        if (gcd_fin) begin
          state_n = ST_DIV;
        end
      end
      ST_DIV: begin
        if (div_fin) begin
          done_n  = 1'b1;
          dep_n   = rem_zero;
          gcd_n   = gcd_val;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      dep_q   <= 1'b0;
      gcd_q   <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      if (done_n) begin
        dep_q <= dep_n;
        gcd_q <= gcd_n;
      end
      if (accept) begin
        gap_q <= gap_mag;
      end
    end
  end

  assign done         = done_q;
  assign dep_possible = dep_q;
  assign gcd_out      = gcd_q;

endmodule

// File: rtl/gcd_dep_tester_sva.sv
module gcd_dep_tester_sva #(
  parameter int unsigned COEF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [COEF_W-1:0] coef_a,
  input logic [COEF_W-1:0] coef_b,
  input logic [COEF_W-1:0] coef_c,
  input logic [COEF_W-1:0] coef_d,
  input logic              done,
  input logic              dep_possible,
  input logic [COEF_W-1:0] gcd_out
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(gcd_out) && $stable(dep_possible)));

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !((coef_a == '0) && (coef_c == '0))) |=> !req_ready);

  assert_no_take_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  assert_zero_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (coef_a == '0) && (coef_c == '0)) |=>
      (done && (gcd_out == '0) && (dep_possible == ($past(coef_b) == $past(coef_d)))));

  assert_unit_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (gcd_out == COEF_W'(1))) |-> dep_possible);

endmodule

bind gcd_dep_tester gcd_dep_tester_sva #(.COEF_W(COEF_W)) u_sva (.*);

// File: tb/gcd_dep_tester_bench.sv
`timescale 1ns/1ps
module gcd_dep_tester_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] coef_a, coef_b, coef_c, coef_d;
  logic        done;
  logic        dep_possible;
  logic [15:0] gcd_out;

  int n_checks = 0;
  int n_fails  = 0;

  gcd_dep_tester u_gcd_dep_tester (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .coef_a       (coef_a),
    .coef_b       (coef_b),
    .coef_c       (coef_c),
    .coef_d       (coef_d),
    .done         (done),
    .dep_possible (dep_possible),
    .gcd_out      (gcd_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_gcd(input int x, input int y);
    int p = (x < 0) ? -x : x;
    int q = (y < 0) ? -y : y;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic run_req(input int a, input int b, input int c, input int d,
                         input string req);
    int exp_g   = ref_gcd(a, c);
    int exp_dep = (exp_g == 0) ? int'(b == d) : int'(((d - b) % exp_g) == 0);
    int waited  = 0;
    bit zpair   = (a == 0) && (c == 0);
    logic [15:0] g_seen;
    logic        d_seen;
    @(negedge clk);
    coef_a = a[15:0]; coef_b = b[15:0]; coef_c = c[15:0]; coef_d = d[15:0];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    coef_a = 16'h1357; coef_b = 16'h0002; coef_c = 16'h2468; coef_d = 16'h0007;
    if (!zpair) chk(req_ready == 1'b0, "R2 ready low while busy", int'(req_ready), 0);
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, {req, " done seen"}, int'(done), 1);
    if (zpair) chk(waited == 0, "R6 done one cycle after take", waited, 0);
    chk(req_ready == 1'b0, "R2 ready low in done cycle", int'(req_ready), 0);
    chk(gcd_out == exp_g[15:0], {req, " R3 divisor"}, int'(gcd_out), exp_g);
    chk(int'(dep_possible) == exp_dep, {req, " R4 verdict"}, int'(dep_possible), exp_dep);
    g_seen = gcd_out;
    d_seen = dep_possible;
    @(negedge clk);
    chk(done == 1'b0, "R7 single-cycle done", int'(done), 0);
    chk(gcd_out == g_seen && dep_possible == d_seen, "R7 result held",
        int'(gcd_out), int'(g_seen));
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R1 done at reset", int'(done), 0);
    chk(dep_possible == 1'b0, "R1 verdict at reset", int'(dep_possible), 0);
    chk(gcd_out == 16'd0, "R1 divisor at reset", int'(gcd_out), 0);
    chk(req_ready == 1'b1, "R1 ready at reset", int'(req_ready), 1);
  endtask

  task automatic t_example;
    run_req(2, 3, 2, 0, "R4 stride-two example");
    run_req(4, 0, 6, 2, "R4 possible case");
  endtask

  task automatic t_mixed_signs;
    run_req(-12, 5, 18, -7, "R3 mixed signs");
    run_req(35, 1, -21, 3, "R3 negative read multiplier");
    run_req(17, 0, 5, 9, "R3 coprime");
  endtask

  task automatic t_one_zero;
    run_req(0, 4, -9, 13, "R5 write multiplier zero");
    run_req(10, 1, 0, 2, "R5 read multiplier zero");
  endtask

  task automatic t_both_zero;
    run_req(0, 5, 0, 5, "R6 equal offsets");
    run_req(0, 5, 0, 6, "R6 different offsets");
  endtask

  task automatic t_extremes;
    run_req(-32768, -32768, -32768, 32767, "R8 most negative");
    run_req(-32768, 0, 16384, -32768, "R8 large gap");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    coef_a = '0; coef_b = '0; coef_c = '0; coef_d = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_mixed_signs();
    t_one_zero();
    t_both_zero();
    t_extremes();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule